// File: doc/BRIEF.md
# Chainable Universal Shift Register

The block is a universal shift register built from identical 8-bit slices that join end to end into a wider word. A 3-bit operation code, sampled on each rising clock edge, selects one of eight actions for the whole word. The actions are hold, parallel load, clear, bitwise invert, logical shift right, rotate right, logical shift left and rotate left.

Each slice has a serial input at each end and shows its two end bits as serial outputs. Neighbouring slices pass bits across the seam through these pins. A slice treats a shift and a rotate the same way: it takes whatever bit arrives on its serial input. Rotation is made only at the wrapper. The wrapper ANDs the far-end bit of the word with a decode of the rotate code and feeds the result back into the opposite serial input. The slice therefore stays usable in any chain length.

The next-state function is pure combinational logic, kept apart from the state flops. An active-low asynchronous reset clears the whole word.

Top module: `shreg_chain`

## Requirements
- R1: While rst_ni is low the word q_o is all zeros, within the same cycle and regardless of op_i.
- R2: op_i = 3'b000 (hold) leaves q_o unchanged at the next rising edge.
- R3: op_i = 3'b001 (load) puts load_data_i into q_o at the next rising edge.
- R4: op_i = 3'b010 (clear) makes q_o all zeros at the next rising edge.
- R5: op_i = 3'b011 (invert) makes q_o the bitwise complement of its previous value.
- R6: op_i = 3'b100 (shift right) moves every bit down one place, and bit W-1 becomes 0.
- R7: op_i = 3'b101 (rotate right) moves every bit down one place, and bit W-1 takes the old bit 0.
- R8: op_i = 3'b110 (shift left) moves every bit up one place, and bit 0 becomes 0.
- R9: op_i = 3'b111 (rotate left) moves every bit up one place, and bit 0 takes the old bit W-1.
- R10: Shifts carry bits across slice seams. Bit 8 of a 16-bit word moves to bit 7 on a right shift, and bit 7 moves to bit 8 on a left shift. Each slice takes its incoming bit from its serial input, whatever the code.
- R11: load_data_i has no effect on q_o for any code other than load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; state changes on the rising edge only |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code (see R2 to R9) |
| load_data_i | input | SLICE_W*N_SLICES | Parallel load word |
| q_o | output | SLICE_W*N_SLICES | Current register word |

## Verification
The assertions assume that op_i and load_data_i are stable around the rising clock edge, and that reset is released away from that edge. The bench meets this by changing inputs only on the falling edge. The serial-input checks in each slice assume that the chain wiring and feedback gate settle within the cycle, since they are purely combinational. The stimulus walks all eight codes on a 16-bit word, with patterns that put set bits at both ends and at the slice seam. It also asserts reset in the middle of a run.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'b000,
    OP_LOAD = 3'b001,
    OP_CLR  = 3'b010,
    OP_INV  = 3'b011,
    OP_SHR  = 3'b100,
    OP_ROR  = 3'b101,
    OP_SHL  = 3'b110,
    OP_ROL  = 3'b111
  } op_e;
endpackage

// File: rtl/shreg_next.sv
module shreg_next
  import shreg_pkg::*;
#(
  parameter int W = 8
) (
  input  op_e          op_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] d_i,
  input  logic         left_in_i,
  input  logic         right_in_i,
  output logic [W-1:0] nxt_o
);
  // shift and rotate share a path: incoming bit always from the serial pin
  always_comb begin
    unique case (op_i)
      OP_HOLD:        nxt_o = q_i;
      OP_LOAD:        nxt_o = d_i;
      OP_CLR:         nxt_o = '0;
      OP_INV:         nxt_o = ~q_i;
      OP_SHR, OP_ROR: nxt_o = {left_in_i, q_i[W-1:1]};
      OP_SHL, OP_ROL: nxt_o = {q_i[W-2:0], right_in_i};
      default:        nxt_o = q_i;
    endcase
  end
endmodule

// File: rtl/shreg_slice.sv
module shreg_slice
  import shreg_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  op_e           op_i,
  input  logic [SW-1:0] d_i,
  input  logic          left_in_i,
  input  logic          right_in_i,
  output logic [SW-1:0] q_o,
  output logic          msb_o,
  output logic          lsb_o
);
  logic [SW-1:0] q_q, q_d;

  shreg_next #(.W(SW)) u_next (
    .op_i      (op_i),
    .q_i       (q_q),
    .d_i       (d_i),
    .left_in_i (left_in_i),
    .right_in_i(right_in_i),
    .nxt_o     (q_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= q_d;
  end

  assign q_o   = q_q;
  assign msb_o = q_q[SW-1];
  assign lsb_o = q_q[0];

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_HOLD |=> q_o == $past(q_o));
  assert_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_LOAD |=> q_o == $past(d_i));
  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_CLR |=> q_o == '0);
  assert_invert_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_INV |=> q_o == ~$past(q_o));
  // R10: right codes take the MSB from left_in_i, left codes take the LSB from right_in_i
  assert_serial_right_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SHR || op_i == OP_ROR) |=>
      q_o == {$past(left_in_i), $past(q_o[SW-1:1])});
  assert_serial_left_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SHL || op_i == OP_ROL) |=>
      q_o == {$past(q_o[SW-2:0]), $past(right_in_i)});
endmodule

// File: rtl/shreg_feedback.sv
module shreg_feedback
  import shreg_pkg::*;
(
  input  op_e  op_i,
  input  logic word_msb_i,
  input  logic word_lsb_i,
  output logic left_in_o,
  output logic right_in_o
);
  // end-around bit only passes on a rotate code; plain shifts fill with 0
  assign left_in_o  = word_lsb_i & (op_i == OP_ROR);
  assign right_in_o = word_msb_i & (op_i == OP_ROL);
endmodule

// File: rtl/shreg_chain.sv
module shreg_chain
  import shreg_pkg::*;
#(
  parameter int SLICE_W  = 8,
  parameter int N_SLICES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [2:0]                  op_i,
  input  logic [SLICE_W*N_SLICES-1:0] load_data_i,
  output logic [SLICE_W*N_SLICES-1:0] q_o
);
  localparam int W = SLICE_W * N_SLICES;

  op_e                op;
  logic [N_SLICES-1:0] s_msb, s_lsb, s_lin, s_rin;
  logic               fb_left, fb_right;

  assign op = op_e'(op_i);

  shreg_feedback u_fb (
    .op_i      (op),
    .word_msb_i(s_msb[N_SLICES-1]),
    .word_lsb_i(s_lsb[0]),
    .left_in_o (fb_left),
    .right_in_o(fb_right)
  );

  for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
    if (k == 0) begin : g_rin_end
      assign s_rin[k] = fb_right;
    end else begin : g_rin_seam
      assign s_rin[k] = s_msb[k-1];
    end
    if (k == N_SLICES - 1) begin : g_lin_end
      assign s_lin[k] = fb_left;
    end else begin : g_lin_seam
      assign s_lin[k] = s_lsb[k+1];
    end

    shreg_slice #(.SW(SLICE_W)) u_slice (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .op_i      (op),
      .d_i       (load_data_i[k*SLICE_W +: SLICE_W]),
      .left_in_i (s_lin[k]),
      .right_in_i(s_rin[k]),
      .q_o       (q_o[k*SLICE_W +: SLICE_W]),
      .msb_o     (s_msb[k]),
      .lsb_o     (s_lsb[k])
    );
  end

  assert_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> q_o == '0);
  assert_shr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'b100 |=> q_o == {1'b0, $past(q_o[W-1:1])});
  assert_ror_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'b101 |=> q_o == {$past(q_o[0]), $past(q_o[W-1:1])});
  assert_shl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'b110 |=> q_o == {$past(q_o[W-2:0]), 1'b0});
  assert_rol_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == 3'b111 |=> q_o == {$past(q_o[W-2:0]), $past(q_o[W-1])});
  assert_no_load_leak_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != 3'b001 && $past(q_o) == q_o && op_i == 3'b000) |=> $stable(q_o));
endmodule

// File: tb/shreg_chain_tb.sv
`timescale 1ns/1ps
module shreg_chain_tb;
  localparam int SW = 8;
  localparam int NS = 2;
  localparam int W  = SW * NS;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   op_i = 3'b000;
  logic [W-1:0] load_data_i = '0;
  logic [W-1:0] q_o;
  logic [W-1:0] ref_q = '0;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  shreg_chain #(.SLICE_W(SW), .N_SLICES(NS)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .op_i       (op_i),
    .load_data_i(load_data_i),
    .q_o        (q_o)
  );

  function automatic logic [W-1:0] model(input logic [W-1:0] q, input logic [2:0] op,
                                         input logic [W-1:0] d);
    case (op)
      3'b000: return q;
      3'b001: return d;
      3'b010: return '0;
      3'b011: return ~q;
      3'b100: return q >> 1;
      3'b101: return {q[0], q[W-1:1]};
      3'b110: return q << 1;
      default: return {q[W-2:0], q[W-1]};
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] exp);
    n_checks++;
    if (q_o !== exp) begin
      n_fail++;
      $display("FAIL %s: q_o=%h expected=%h", tag, q_o, exp);
    end
  endtask

  // called at a falling edge; applies one code for exactly one rising edge
  task automatic step(input logic [2:0] op, input logic [W-1:0] d, input string tag);
    op_i = op;
    load_data_i = d;
    ref_q = model(ref_q, op, d);
    @(negedge clk);
    check(tag, ref_q);
  endtask

  task automatic t_reset;
    op_i = 3'b001; load_data_i = 16'hFFFF;
    @(negedge clk);
    check("R1 held in reset", 16'h0000);
    rst_ni = 1'b1; op_i = 3'b000;
    @(negedge clk);
    check("R1 after release", 16'h0000);
  endtask

  task automatic t_load_hold;
    step(3'b001, 16'hA5C3, "R3 load");
    check("R3 load literal", 16'hA5C3);
    step(3'b000, 16'h1234, "R2 hold");
    step(3'b000, 16'hFFFF, "R11 hold ignores data");
    for (int i = 2; i < 8; i++) begin
      if (i == 3) continue;
      step(3'b001, 16'h00F0, "R3 reload");
      step(3'(i), 16'hFFFF, "R11 data ignored off load");
    end
  endtask

  task automatic t_clear_invert;
    step(3'b001, 16'hA5C3, "R3 load");
    step(3'b011, 16'h0000, "R5 invert");
    check("R5 invert literal", 16'h5A3C);
    step(3'b011, 16'h0000, "R5 invert back");
    step(3'b010, 16'hFFFF, "R4 clear");
    check("R4 clear literal", 16'h0000);
  endtask

  task automatic t_shift_right;
    step(3'b001, 16'hA5C3, "R3 load");
    step(3'b100, 16'h0000, "R6 shift right");
    check("R6 literal", 16'h52E1);
    for (int i = 0; i < 16; i++) step(3'b100, 16'h0000, "R6 drain");
    check("R6 drained to zero", 16'h0000);
    step(3'b001, 16'h0100, "R3 load");
    step(3'b100, 16'h0000, "R10 seam right");
    check("R10 seam right literal", 16'h0080);
  endtask

  task automatic t_rotate_right;
    step(3'b001, 16'h001F, "R3 load");
    step(3'b101, 16'h0000, "R7 rotate right");
    check("R7 literal", 16'h800F);
    step(3'b001, 16'hFFFF, "R3 load");
    for (int i = 0; i < 5; i++) step(3'b101, 16'h0000, "R7 all ones stays");
    step(3'b001, 16'h8421, "R3 load");
    for (int i = 0; i < 16; i++) step(3'b101, 16'h0000, "R7 full turn");
    check("R7 full turn literal", 16'h8421);
  endtask

  task automatic t_shift_left;
    step(3'b001, 16'h8001, "R3 load");
    step(3'b110, 16'h0000, "R8 shift left");
    check("R8 literal", 16'h0002);
    step(3'b001, 16'h0080, "R3 load");
    step(3'b110, 16'h0000, "R10 seam left");
    check("R10 seam left literal", 16'h0100);
  endtask

  task automatic t_rotate_left;
    step(3'b001, 16'h8001, "R3 load");
    step(3'b111, 16'h0000, "R9 rotate left");
    check("R9 literal", 16'h0003);
    for (int i = 0; i < 15; i++) step(3'b111, 16'h0000, "R9 walk");
    check("R9 walk literal", 16'h8001);
  endtask

  task automatic t_async_reset;
    step(3'b001, 16'hBEEF, "R3 load");
    #1 rst_ni = 1'b0;
    #0.5 check("R1 async clear", 16'h0000);
    ref_q = '0;
    @(negedge clk);
    check("R1 still in reset", 16'h0000);
    rst_ni = 1'b1;
    step(3'b011, 16'h0000, "R5 invert after reset");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_load_hold();
    t_clear_invert();
    t_shift_right();
    t_rotate_right();
    t_shift_left();
    t_rotate_left();
    t_async_reset();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: q_o=%h expected=completion", q_o);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule